// File: doc/BRIEF.md
# Linked-Period Multi-Output PWM Timer

This block is a bank of down-counting timer channels in which one channel sets a common PWM period and two channels above it each produce a PWM waveform with a duty of their own. The period channel reloads its programmed value every time it counts through zero. Each such reload pulses its interrupt line and restarts every duty channel linked to it. Because the duty channels have no period of their own, all the waveforms in a group share one period and keep the same phase.

Software configures each channel through a narrow write port. A write selects the channel, then one of three fields: the role, the count value, or the output settings (resting level, inversion, pin drive). Channels start and stop through per-channel one-cycle strobes. Counting advances only on cycles where the count-clock enable is high. A unit enable freezes the whole bank and blocks every write while it is low. Each channel's pin has a level output and a drive-enable output. When the drive enable is low, the pad is meant to float at high impedance.

Top module: `pwm_timer_array`

## Requirements
- R1: After reset, every level_o, drive_o and irq_o bit is 0, and every channel is idle with count value 0.
- R2: A write with wr_en_i high updates only channel wr_ch_i. The field is chosen by wr_fld_i. Field 0 sets the role from wr_data_i[1:0]: 0 idle, 1 period channel, 2 duty channel. Field 1 sets the count value. Field 2 sets the outputs: bit 0 is the resting level, bit 1 inverts the active level, bit 2 enables pin drive.
- R3: A start strobe on a period channel with value P makes its irq_o bit high in the cycle after the start edge. The channel then pulses irq_o again every P+1 count-clock ticks.
- R4: Duty channel i follows the period channel 2*floor((i-1)/2), so channel 0 has slaves 1 and 2, channel 2 has slaves 3 and 4, and channel 4 has slaves 5 and 6. A started duty channel loads its duty D at each event of its period channel. It is active from that event until D ticks have elapsed.
- R5: A duty of 0 gives a permanently inactive output. A duty greater than the period value gives a permanently active output.
- R6: level_o shows the active state XOR the inversion bit.
- R7: A resting-level write to a channel that is not running appears on level_o after the write edge. Before the first event after a start, the output keeps its current level.
- R8: drive_o of each channel equals its enable bit from field 2; the pad is high impedance while it is 0.
- R9: A stop strobe halts the channel at that edge. Its level_o stays frozen and it raises no further interrupts.
- R10: A count-value write made while running first takes effect at the next period event after the write edge.
- R11: While unit_en_i is low, writes, starts, stops and ticks have no effect and no interrupt is raised.
- R12: Counters advance only on edges where tick_i is high. Start edges count no tick.
- R13: A duty channel pulses its irq_o bit in the cycle after its count reaches zero, which happens only when 1 <= D <= P.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| unit_en_i | input | 1 | Unit enable; low freezes the bank and blocks writes |
| tick_i | input | 1 | Count-clock enable |
| wr_en_i | input | 1 | Register write strobe |
| wr_ch_i | input | CH_W | Channel addressed by the write |
| wr_fld_i | input | 2 | Field selector (0 role, 1 value, 2 output settings) |
| wr_data_i | input | W | Write data |
| start_i | input | NCH | Per-channel start strobes |
| stop_i | input | NCH | Per-channel stop strobes |
| irq_o | output | NCH | Per-channel interrupt pulses |
| level_o | output | NCH | Per-channel pin level |
| drive_o | output | NCH | Per-channel pin drive enable (low = high impedance) |

## Verification
A period channel whose counter state is wrong shows at the ports as an interrupt in the wrong place. The spacing between interrupts departs from P+1 ticks within one period. The duty outputs in its group also restart at the wrong time. A wrong duty counter or active flag shows on level_o at the next period event, or as a duty interrupt at the wrong phase in the same period. A stale or missed stop shows up on the very next edge, either as a changed level or as an interrupt after the stop.

// File: rtl/pwm_tmr_pkg.sv
package pwm_tmr_pkg;

  typedef enum logic [1:0] {
    MODE_IDLE   = 2'd0,
    MODE_PERIOD = 2'd1,
    MODE_DUTY   = 2'd2
  } chan_mode_e;

  typedef enum logic [1:0] {
    FLD_MODE   = 2'd0,
    FLD_VALUE  = 2'd1,
    FLD_OUTCFG = 2'd2
  } wr_fld_e;

  localparam int OUTCFG_DFLT_BIT = 0;
  localparam int OUTCFG_INV_BIT  = 1;
  localparam int OUTCFG_OE_BIT   = 2;

  // Index of the period channel that drives duty channel idx (idx >= 1).
  function automatic int master_of(input int idx);
    return ((idx - 1) / 2) * 2;
  endfunction

  // Pin level from the internal active flag and the inversion setting.
  function automatic logic pin_level(input logic act, input logic inv);
    return act ^ inv;
  endfunction

  // Active flag right after a duty load.
  function automatic logic load_active(input logic nonzero_duty);
    return nonzero_duty;
  endfunction

endpackage

// File: rtl/pwm_tmr_regs.sv
module pwm_tmr_regs
  import pwm_tmr_pkg::*;
#(
  parameter int NCH = 8,
  parameter int W   = 16,
  localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             unit_en,
  input  logic             wr_en,
  input  logic [CH_W-1:0]  wr_ch,
  input  logic [1:0]       wr_fld,
  input  logic [W-1:0]     wr_data,
  output chan_mode_e       mode_q  [NCH],
  output logic [W-1:0]     value_q [NCH],
  output logic [NCH-1:0]   inv_q,
  output logic [NCH-1:0]   oe_q,
  output logic [NCH-1:0]   dflt_ld
);

  for (genvar i = 0; i < NCH; i++) begin : g_reg
    logic hit;
    assign hit        = unit_en && wr_en && (wr_ch == CH_W'(i));
    assign dflt_ld[i] = hit && (wr_fld_e'(wr_fld) == FLD_OUTCFG);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mode_q[i]  <= MODE_IDLE;
        value_q[i] <= '0;
        inv_q[i]   <= 1'b0;
        oe_q[i]    <= 1'b0;
      end else if (hit) begin
        unique case (wr_fld_e'(wr_fld))
          FLD_MODE:   mode_q[i]  <= chan_mode_e'(wr_data[1:0]);
          FLD_VALUE:  value_q[i] <= wr_data;
          FLD_OUTCFG: begin
            inv_q[i] <= wr_data[OUTCFG_INV_BIT];
            oe_q[i]  <= wr_data[OUTCFG_OE_BIT];
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/pwm_tmr_chan.sv
module pwm_tmr_chan
  import pwm_tmr_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         unit_en,
  input  logic         tick,
  input  logic         start,
  input  logic         stop,
  input  chan_mode_e   mode,
  input  logic [W-1:0] value,
  input  logic         link_ev,
  output logic         mev_o,
  output logic         sfire_o,
  output logic         upd_o,
  output logic         act_nxt_o,
  output logic         run_o
);

  logic         run_q, live_q, act_q;
  logic [W-1:0] cnt_q;
  logic         is_p, is_d, go, halt, cnt_zero, sload, sdec;

  assign is_p     = (mode == MODE_PERIOD);
  assign is_d     = (mode == MODE_DUTY);
  assign go       = unit_en && start && (is_p || is_d);
  assign halt     = unit_en && stop;
  assign cnt_zero = (cnt_q == '0);

  // Period event: start edge, or a tick while the count sits at zero.
  assign mev_o   = unit_en && !halt && is_p && (go || (run_q && tick && cnt_zero));
  // Duty load on the linked period event; decrement on other ticks.
  assign sload   = unit_en && !halt && is_d && (go || run_q) && link_ev;
  assign sdec    = unit_en && !halt && is_d && run_q && live_q && !link_ev
                   && tick && !cnt_zero;
  assign sfire_o = sdec && (cnt_q == W'(1));
  assign upd_o   = sload || sdec;
  assign run_o   = run_q;

  always_comb begin
    act_nxt_o = act_q;
    if (sload)     act_nxt_o = load_active(value != '0);
    else if (sdec) act_nxt_o = (cnt_q != W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      live_q <= 1'b0;
      act_q  <= 1'b0;
      cnt_q  <= '0;
    end else if (halt) begin
      run_q  <= 1'b0;
      live_q <= 1'b0;
    end else begin
      if (go) run_q <= 1'b1;
      act_q <= act_nxt_o;
      if (is_p) begin
        if (mev_o)                            cnt_q <= value;
        else if (unit_en && run_q && tick)    cnt_q <= cnt_q - W'(1);
      end else if (is_d) begin
        if (sload) begin
          cnt_q  <= value;
          live_q <= 1'b1;
        end else if (sdec) begin
          cnt_q <= cnt_q - W'(1);
        end else if (go) begin
          live_q <= 1'b0;
        end
      end
    end
  end

endmodule

// File: rtl/pwm_tmr_outs.sv
module pwm_tmr_outs
  import pwm_tmr_pkg::*;
#(
  parameter int NCH = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] upd,
  input  logic [NCH-1:0] act_nxt,
  input  logic [NCH-1:0] inv,
  input  logic [NCH-1:0] run,
  input  logic [NCH-1:0] dflt_ld,
  input  logic           dflt_val,
  input  logic [NCH-1:0] mev,
  input  logic [NCH-1:0] sfire,
  output logic [NCH-1:0] level_o,
  output logic [NCH-1:0] irq_o
);

  for (genvar i = 0; i < NCH; i++) begin : g_out
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        level_o[i] <= 1'b0;
        irq_o[i]   <= 1'b0;
      end else begin
        irq_o[i] <= mev[i] || sfire[i];
        if (upd[i])                      level_o[i] <= pin_level(act_nxt[i], inv[i]);
        else if (dflt_ld[i] && !run[i])  level_o[i] <= dflt_val;
      end
    end
  end

endmodule

// File: rtl/pwm_timer_array.sv
module pwm_timer_array
  import pwm_tmr_pkg::*;
#(
  parameter int NCH = 8,
  parameter int W   = 16,
  localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            unit_en_i,
  input  logic            tick_i,
  input  logic            wr_en_i,
  input  logic [CH_W-1:0] wr_ch_i,
  input  logic [1:0]      wr_fld_i,
  input  logic [W-1:0]    wr_data_i,
  input  logic [NCH-1:0]  start_i,
  input  logic [NCH-1:0]  stop_i,
  output logic [NCH-1:0]  irq_o,
  output logic [NCH-1:0]  level_o,
  output logic [NCH-1:0]  drive_o
);

  chan_mode_e     mode_q  [NCH];
  logic [W-1:0]   value_q [NCH];
  logic [NCH-1:0] inv_q, oe_q, dflt_ld;
  logic [NCH-1:0] master_ev, slave_fire, upd, act_nxt, run, link_ev, is_master;

  pwm_tmr_regs #(.NCH(NCH), .W(W)) regs_i (
    .clk     (clk_i),
    .rst_n   (rst_ni),
    .unit_en (unit_en_i),
    .wr_en   (wr_en_i),
    .wr_ch   (wr_ch_i),
    .wr_fld  (wr_fld_i),
    .wr_data (wr_data_i),
    .mode_q  (mode_q),
    .value_q (value_q),
    .inv_q   (inv_q),
    .oe_q    (oe_q),
    .dflt_ld (dflt_ld)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    if (i == 0) begin : g_nolink
      assign link_ev[i] = 1'b0;
    end else begin : g_link
      assign link_ev[i] = master_ev[master_of(i)];
    end
    assign is_master[i] = (mode_q[i] == MODE_PERIOD);

    pwm_tmr_chan #(.W(W)) chan_i (
      .clk       (clk_i),
      .rst_n     (rst_ni),
      .unit_en   (unit_en_i),
      .tick      (tick_i),
      .start     (start_i[i]),
      .stop      (stop_i[i]),
      .mode      (mode_q[i]),
      .value     (value_q[i]),
      .link_ev   (link_ev[i]),
      .mev_o     (master_ev[i]),
      .sfire_o   (slave_fire[i]),
      .upd_o     (upd[i]),
      .act_nxt_o (act_nxt[i]),
      .run_o     (run[i])
    );
  end

  pwm_tmr_outs #(.NCH(NCH)) outs_i (
    .clk      (clk_i),
    .rst_n    (rst_ni),
    .upd      (upd),
    .act_nxt  (act_nxt),
    .inv      (inv_q),
    .run      (run),
    .dflt_ld  (dflt_ld),
    .dflt_val (wr_data_i[OUTCFG_DFLT_BIT]),
    .mev      (master_ev),
    .sfire    (slave_fire),
    .level_o  (level_o),
    .irq_o    (irq_o)
  );

  assign drive_o = oe_q;

endmodule

// File: rtl/pwm_timer_array_chk.sv
module pwm_timer_array_chk #(
  parameter int NCH = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           unit_en,
  input logic           tick,
  input logic           wr_en,
  input logic [NCH-1:0] start,
  input logic [NCH-1:0] stop,
  input logic [NCH-1:0] irq,
  input logic [NCH-1:0] level,
  input logic [NCH-1:0] sfire,
  input logic [NCH-1:0] inv,
  input logic [NCH-1:0] is_master
);

  // R11
  unit_off_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !unit_en |=> ($stable(level) && (irq == '0)));

  // R12
  no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (unit_en && !tick && (start == '0) && (stop == '0) && !wr_en) |=> $stable(level));

  for (genvar i = 0; i < NCH; i++) begin : g_chk
    // R9
    stop_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (unit_en && stop[i] && !wr_en) |=> ($stable(level[i]) && !irq[i]));

    // R3
    start_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (unit_en && start[i] && !stop[i] && is_master[i]) |=> irq[i]);

    // R13
    duty_end_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sfire[i] && !wr_en) |=> ((level[i] == $past(inv[i])) && irq[i]));
  end

endmodule

bind pwm_timer_array pwm_timer_array_chk #(.NCH(NCH)) chk_i (
  .clk       (clk_i),
  .rst_n     (rst_ni),
  .unit_en   (unit_en_i),
  .tick      (tick_i),
  .wr_en     (wr_en_i),
  .start     (start_i),
  .stop      (stop_i),
  .irq       (irq_o),
  .level     (level_o),
  .sfire     (slave_fire),
  .inv       (inv_q),
  .is_master (is_master)
);

// File: tb/pwm_timer_array_tb.sv
`timescale 1ns/1ps
module pwm_timer_array_tb_top;
  localparam int NCH = 8;
  localparam int W   = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic           unit_en = 1'b0, tick = 1'b0, wr_en = 1'b0;
  logic [2:0]     wr_ch = '0;
  logic [1:0]     wr_fld = '0;
  logic [W-1:0]   wr_data = '0;
  logic [NCH-1:0] start = '0, stop = '0;
  logic [NCH-1:0] irq, lvl, drv;

  pwm_timer_array #(.NCH(NCH), .W(W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .unit_en_i(unit_en), .tick_i(tick),
    .wr_en_i(wr_en), .wr_ch_i(wr_ch), .wr_fld_i(wr_fld), .wr_data_i(wr_data),
    .start_i(start), .stop_i(stop), .irq_o(irq), .level_o(lvl), .drive_o(drv)
  );

  typedef struct {
    logic [NCH-1:0] lvl;
    logic [NCH-1:0] drv;
    logic [NCH-1:0] irq;
    string          tag;
  } exp_t;

  exp_t exp_q[$];
  int checks = 0;
  int failures = 0;
  logic [NCH-1:0] cur_lvl = '0;
  logic [NCH-1:0] cur_drv = '0;
  localparam logic [NCH-1:0] GRP = 8'h07;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [NCH-1:0] act, input logic [NCH-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
    end
  endtask

  // Monitor: pops one expected item per falling edge.
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      check(lvl === e.lvl, e.tag, "level", lvl, e.lvl);
      check(drv === e.drv, e.tag, "drive", drv, e.drv);
      check(irq === e.irq, e.tag, "irq",   irq, e.irq);
    end
  end

  task automatic wr(input int ch, input int fld, input int data);
    @(negedge clk);
    wr_en = 1'b1; wr_ch = 3'(ch); wr_fld = 2'(fld); wr_data = W'(data);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic expect_static(input int n, input logic [NCH-1:0] l,
                               input logic [NCH-1:0] d, input string tag);
    exp_t e;
    @(posedge clk);
    for (int k = 0; k < n; k++) begin
      e.lvl = l; e.drv = d; e.irq = '0; e.tag = tag;
      exp_q.push_back(e);
    end
    repeat (n) @(negedge clk);
  endtask

  // Drives one PWM group (channel 0 period, 1 and 2 duty) and queues the
  // expected per-cycle pin state. Tick counting: after edge j there have been
  // j/div ticks; a duty channel is active while the phase is below its duty.
  task automatic pwm_run(input int p, input int d1, input int d2,
                         input bit inv1, input bit inv2, input int div,
                         input int n_run, input int n_hold,
                         input int wr_at, input int d1_new, input string tag);
    int total;
    exp_t e;
    total = n_run + n_hold;
    @(negedge clk);
    start = GRP; tick = 1'b1;
    @(posedge clk);
    for (int j = 0; j < total; j++) begin
      int jj, k, ph, evj, d1e;
      bit ticked, live, a1, a2;
      jj     = (j < n_run) ? j : n_run - 1;
      live   = (j < n_run);
      k      = jj / div;
      ticked = (jj > 0) && (jj % div == 0);
      ph     = k % (p + 1);
      evj    = (k - ph) * div;
      d1e    = (wr_at > 0 && evj > wr_at) ? d1_new : d1;
      a1     = (ph < d1e);
      a2     = (ph < d2);
      e.lvl = '0; e.irq = '0;
      e.lvl[1] = a1 ^ inv1;
      e.lvl[2] = a2 ^ inv2;
      e.irq[0] = live && (jj == 0 || (ticked && ph == 0));
      e.irq[1] = live && ticked && d1e >= 1 && d1e <= p && ph == d1e;
      e.irq[2] = live && ticked && d2 >= 1 && d2 <= p && ph == d2;
      e.drv = cur_drv; e.tag = tag;
      exp_q.push_back(e);
      cur_lvl = e.lvl;
    end
    for (int j = 0; j < total; j++) begin
      @(negedge clk);
      start = '0;
      tick  = ((j + 1) % div == 0);
      stop  = (j + 1 == n_run) ? GRP : '0;
      if (j + 1 == wr_at) begin
        wr_en = 1'b1; wr_ch = 3'd1; wr_fld = 2'd1; wr_data = W'(d1_new);
      end else begin
        wr_en = 1'b0;
      end
    end
    tick = 1'b0; stop = '0; wr_en = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R1 reset state
    expect_static(2, '0, '0, "R1");

    unit_en = 1'b1;
    // R2 field encodings: role 1 period, 2 duty; outcfg bit0 rest, bit1 inv, bit2 drive
    wr(0, 0, 1); wr(0, 1, 4);
    wr(1, 0, 2); wr(1, 1, 2); wr(1, 2, 3'b100);
    wr(2, 0, 2); wr(2, 1, 6); wr(2, 2, 3'b111);
    cur_drv = 8'b0000_0110;
    // R7 resting level shown before start, R8 drive follows enable
    expect_static(2, 8'b0000_0100, cur_drv, "R2 R7 R8");

    // R3 R4 R5 R6 R9 R13: period 4, duty 2 and duty 6 (>P, inverted), then stop
    pwm_run(4, 2, 6, 1'b0, 1'b1, 1, 12, 4, 0, 0, "R3 R4 R5 R6 R9 R13");

    // R5 duty 0, R10 duty change mid-period applies at next boundary
    wr(1, 1, 1); wr(2, 1, 0);
    pwm_run(4, 1, 0, 1'b0, 1'b1, 1, 15, 2, 2, 3, "R5 R10");

    // R12 tick every second cycle, R13 duty equal to period
    wr(0, 1, 2); wr(1, 1, 1); wr(2, 1, 2);
    pwm_run(2, 1, 2, 1'b0, 1'b1, 2, 14, 2, 0, 0, "R12 R13");

    // R11 unit disabled: write, start and ticks ignored
    unit_en = 1'b0;
    wr(1, 1, 3);
    wr(2, 2, 3'b001);
    @(negedge clk); start = GRP; tick = 1'b1;
    @(negedge clk); start = '0; tick = 1'b0;
    expect_static(3, cur_lvl, cur_drv, "R11");
    unit_en = 1'b1;
    wr(0, 1, 3);
    pwm_run(3, 1, 2, 1'b0, 1'b1, 1, 9, 2, 0, 0, "R11 R4");

    // R7 R8: resting level on a stopped channel, drive disabled
    wr(2, 2, 3'b010);
    cur_drv = 8'b0000_0010;
    cur_lvl[2] = 1'b0;
    expect_static(2, cur_lvl, cur_drv, "R7 R8");

    repeat (2) @(negedge clk);
    check(exp_q.size() == 0, "R1", "queue drained", NCH'(exp_q.size()), '0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule